// File: doc/BRIEF.md
# Packet Timestamp Capture Memory

This block samples the port timer when a packet crosses the port and keeps each sample in a small indexed memory. A receive strobe always produces a capture. A transmit strobe produces a capture only when the transmit path asks for one, and it names the slot it wants. Each port owns its own group of slots. Each slot holds a 40-bit value and a flag that marks the slot as holding an unread sample. The stored value is the timer field holding the whole nanoseconds plus the upper fraction bits, cut to 40 bits at the strobe.

Software reads a slot through two 32-bit registers. The low register returns the bottom 32 bits of the sample. The high register returns the top 8 bits and the occupied flag, so software can poll that register until the sample appears. A slot is released by writing zero to it. A per-port pending output shows that at least one slot of the port holds a sample. A one-cycle overflow pulse reports a capture that had no slot to go to.

Top module: `ts_capture_mem`

## Requirements
- R1: After reset every slot is empty, `reg_rdata` is 0, and `ovf` and `ts_pending` are 0.
- R2: A pulse on `rx_cap[p]` stores `timer[CAP_LSB+39:CAP_LSB]` in the lowest-numbered empty slot of port p and marks that slot occupied. The change is visible from the next clock edge.
- R3: A pulse on `tx_cap[p]` stores the timer sample in slot `tx_slot[p]` of port p when that slot is empty. While `tx_cap[p]` is low, no transmit capture happens, whatever `tx_slot` and `timer` do.
- R4: When receive and transmit strobes hit the same port in the same cycle, the transmit capture takes its named slot. The receive capture takes the lowest empty slot other than that one.
- R5: A transmit request to an occupied slot, or a receive strobe with no empty slot, is dropped and leaves every slot unchanged. It raises `ovf[p]` for exactly the one cycle after the strobe.
- R6: `reg_addr` is {bank, port, index}, with bank as the MSB: 0 selects the low register, 1 the high register. The low register reads sample bits 31:0. The high register reads sample bits 39:32 in bits 7:0 and the occupied flag in bit 31, with all other bits zero. `reg_rdata` updates in the cycle after `reg_rd` and holds at all other times.
- R7: Writing 0 to a low register clears the low 32 bits of the slot. Writing 0 to a high register clears the top 8 bits and the occupied flag, and the slot becomes available to receive captures again.
- R8: A write with a nonzero data word has no effect.
- R9: When a capture and a zero write target the same slot in the same cycle, the capture is kept and the slot ends up occupied.
- R10: `ts_pending[p]` is high exactly while at least one slot of port p is occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| timer | input | TIMER_W | Port timer value |
| rx_cap | input | NUM_PORTS | Receive capture strobe, one bit per port |
| tx_cap | input | NUM_PORTS | Transmit capture request, one bit per port |
| tx_slot | input | NUM_PORTS*IDX_W | Target slot index for each port's transmit request |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {bank, port, index} |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| ovf | output | NUM_PORTS | One-cycle pulse for a dropped capture |
| ts_pending | output | NUM_PORTS | Port has at least one occupied slot |

## Verification
A strobe driven before a rising edge changes the slot state at that edge. So `ts_pending` and `ovf` are due at the following falling edge, and `ovf` must be low again one cycle later. A read raised before an edge presents its data after that edge. The driver pushes the expected word into a queue when it raises `reg_rd`, and the monitor pops and compares one falling edge later, once it has seen the read strobe registered. All stimulus changes and all sampling happen on falling edges, so every comparison lands exactly one register stage after its cause.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    localparam int REG_W     = 32;
    localparam int TS_W      = 40;
    localparam int LOW_W     = 32;
    localparam int HI_W      = TS_W - LOW_W;
    localparam int PAD_W     = REG_W - 1 - HI_W;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;
endpackage

// File: rtl/tsc_free_pick.sv
module tsc_free_pick #(
    parameter  int SLOTS = 4,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // lowest-numbered free entry wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tsc_addr_split.sv
module tsc_addr_split
    import tsc_pkg::*;
#(
    parameter int SLOT_W = 3
) (
    input  logic [SLOT_W:0]   addr,
    output bank_e             bank,
    output logic [SLOT_W-1:0] slot
);
    assign bank = bank_e'(addr[SLOT_W]);
    assign slot = addr[SLOT_W-1:0];
endmodule

// File: rtl/ts_capture_mem.sv
module ts_capture_mem
    import tsc_pkg::*;
#(
    parameter  int NUM_PORTS = 2,
    parameter  int SLOTS     = 4,
    parameter  int TIMER_W   = 64,
    parameter  int CAP_LSB   = 24,
    localparam int IDX_W     = $clog2(SLOTS),
    localparam int NUM_SLOTS = NUM_PORTS * SLOTS,
    localparam int SLOT_W    = $clog2(NUM_SLOTS),
    localparam int ADDR_W    = SLOT_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIMER_W-1:0]         timer,
    input  logic [NUM_PORTS-1:0]       rx_cap,
    input  logic [NUM_PORTS-1:0]       tx_cap,
    input  logic [NUM_PORTS*IDX_W-1:0] tx_slot,
    input  logic                       reg_rd,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output logic [NUM_PORTS-1:0]       ovf,
    output logic [NUM_PORTS-1:0]       ts_pending
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0][LOW_W-1:0] lo;
        logic [NUM_SLOTS-1:0][HI_W-1:0]  hi;
        logic [NUM_SLOTS-1:0]            valid;
        logic [NUM_PORTS-1:0]            ovf;
        logic [REG_W-1:0]                rdata;
    } state_t;

    state_t st_d, st_q;

    logic [TS_W-1:0]            cap_word;
    bank_e                      acc_bank;
    logic [SLOT_W-1:0]          acc_slot;
    logic [NUM_PORTS-1:0]       rx_found;
    logic [NUM_PORTS*IDX_W-1:0] rx_idx;
    logic [NUM_SLOTS-1:0]       slot_valid;

    assign cap_word = timer[CAP_LSB +: TS_W];

    generate
        if (CAP_LSB > 0) begin : g_frac_drop
            logic unused_frac_bits;
            assign unused_frac_bits = ^timer[CAP_LSB-1:0];
        end
        if (CAP_LSB + TS_W < TIMER_W) begin : g_top_drop
            logic unused_top_bits;
            assign unused_top_bits = ^timer[TIMER_W-1:CAP_LSB+TS_W];
        end
    endgenerate

    tsc_addr_split #(.SLOT_W(SLOT_W)) u_addr (
        .addr (reg_addr),
        .bank (acc_bank),
        .slot (acc_slot)
    );

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
            logic [SLOTS-1:0] excl;
            logic [SLOTS-1:0] busy;

            // a same-cycle transmit request reserves its slot
            always_comb begin
                excl = '0;
                if (tx_cap[p]) excl[tx_slot[p*IDX_W +: IDX_W]] = 1'b1;
            end
            assign busy = st_q.valid[p*SLOTS +: SLOTS] | excl;

            tsc_free_pick #(.SLOTS(SLOTS)) u_pick (
                .busy  (busy),
                .found (rx_found[p]),
                .idx   (rx_idx[p*IDX_W +: IDX_W])
            );

            assign ts_pending[p] = |st_q.valid[p*SLOTS +: SLOTS];
        end
    endgenerate

    always_comb begin
        logic [NUM_SLOTS-1:0] cap_set;
        logic [SLOT_W-1:0]    tx_s;
        logic [SLOT_W-1:0]    rx_s;

        st_d     = st_q;
        st_d.ovf = '0;
        cap_set  = '0;
        tx_s     = '0;
        rx_s     = '0;

        for (int p = 0; p < NUM_PORTS; p++) begin
            tx_s = SLOT_W'(p * SLOTS) + SLOT_W'(tx_slot[p*IDX_W +: IDX_W]);
            rx_s = SLOT_W'(p * SLOTS) + SLOT_W'(rx_idx[p*IDX_W +: IDX_W]);
            if (tx_cap[p]) begin
                if (st_q.valid[tx_s]) st_d.ovf[p] = 1'b1;
                else                  cap_set[tx_s] = 1'b1;
            end
            if (rx_cap[p]) begin
                if (rx_found[p]) cap_set[rx_s] = 1'b1;
                else             st_d.ovf[p]   = 1'b1;
            end
        end

        // zero writes release; captures applied afterwards so they win
        if (reg_wr && (reg_wdata == '0)) begin
            if (acc_bank == BANK_HI) begin
                st_d.hi[acc_slot]    = '0;
                st_d.valid[acc_slot] = 1'b0;
            end else begin
                st_d.lo[acc_slot] = '0;
            end
        end

        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (cap_set[s]) begin
                st_d.lo[s]    = cap_word[LOW_W-1:0];
                st_d.hi[s]    = cap_word[TS_W-1:LOW_W];
                st_d.valid[s] = 1'b1;
            end
        end

        if (reg_rd) begin
            if (acc_bank == BANK_HI)
                st_d.rdata = {st_q.valid[acc_slot], {PAD_W{1'b0}}, st_q.hi[acc_slot]};
            else
                st_d.rdata = st_q.lo[acc_slot];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata  = st_q.rdata;
    assign ovf        = st_q.ovf;
    assign slot_valid = st_q.valid;
endmodule

// File: rtl/ts_capture_mem_chk.sv
module ts_capture_mem_chk #(
    parameter  int NUM_PORTS = 2,
    parameter  int SLOTS     = 4,
    localparam int IDX_W     = $clog2(SLOTS),
    localparam int NUM_SLOTS = NUM_PORTS * SLOTS,
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] rx_cap,
    input logic [NUM_PORTS-1:0] tx_cap,
    input logic [IDX_W-1:0]     tx_slot0,
    input logic                 reg_rd,
    input logic                 reg_wr,
    input logic [SLOT_W:0]      reg_addr,
    input logic [31:0]          reg_wdata,
    input logic [31:0]          reg_rdata,
    input logic                 ovf0,
    input logic [NUM_SLOTS-1:0] slot_valid
);
    logic [SLOTS-1:0]  v0;
    logic [SLOT_W-1:0] clr_slot;
    logic              clr_hi;

    assign v0       = slot_valid[SLOTS-1:0];
    assign clr_slot = reg_addr[SLOT_W-1:0];
    assign clr_hi   = reg_addr[SLOT_W];

    p_rx_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cap[0] && !tx_cap[0] && !reg_wr && !(&v0))
        |=> ($countones(slot_valid[SLOTS-1:0]) == $past($countones(v0)) + 1));

    p_tx_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cap[0] && !v0[tx_slot0]) |=> slot_valid[$past(tx_slot0)]);

    p_no_spurious_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cap == '0 && tx_cap == '0) |=> ((slot_valid & ~$past(slot_valid)) == '0));

    p_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cap[0] && v0[tx_slot0]) |=> ovf0);

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_cap[0] && !rx_cap[0]) |=> !ovf0);

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && clr_hi && reg_wdata == '0 && rx_cap == '0 && tx_cap == '0)
        |=> !slot_valid[$past(clr_slot)]);
endmodule

bind ts_capture_mem ts_capture_mem_chk #(
    .NUM_PORTS (NUM_PORTS),
    .SLOTS     (SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_cap     (rx_cap),
    .tx_cap     (tx_cap),
    .tx_slot0   (tx_slot[IDX_W-1:0]),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ovf0       (ovf[0]),
    .slot_valid (slot_valid)
);

// File: tb/ts_capture_mem_tb.sv
module ts_capture_mem_tb;
    localparam int NP = 2;
    localparam int SL = 4;
    localparam int NS = NP * SL;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] timer = '0;
    logic [1:0]  rx_cap = '0;
    logic [1:0]  tx_cap = '0;
    logic [3:0]  tx_slot = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  ovf;
    logic [1:0]  ts_pending;

    always #10 clk = ~clk;

    ts_capture_mem u_dut (
        .clk(clk), .rst_n(rst_n), .timer(timer), .rx_cap(rx_cap), .tx_cap(tx_cap),
        .tx_slot(tx_slot), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf(ovf), .ts_pending(ts_pending)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] m_lo [NS];
    logic [7:0]  m_hi [NS];
    logic        m_v  [NS];

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] adr(input logic bank, input int port, input int idx);
        return {bank, 1'(port), 2'(idx)};
    endfunction

    // monitor: compare the registered read data one cycle after the strobe
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(reg_rdata, 32'hx, "R6 unexpected read");
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(reg_rdata, e, t);
            end
        end
    end

    // driver: read a register, expected word from the model
    task automatic rd(input logic [3:0] a, input string tag);
        int s;
        s = int'(a[2:0]);
        reg_rd   = 1'b1;
        reg_addr = a;
        if (a[3]) exp_q.push_back({m_v[s], 23'b0, m_hi[s]});
        else      exp_q.push_back(m_lo[s]);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // one stimulus cycle with the model updated from the requirements
    task automatic op(input logic [1:0] rxm, input logic [1:0] txm,
                      input int s0, input int s1, input logic [63:0] t,
                      input logic wr, input logic [3:0] a, input logic [31:0] wd,
                      input string tag);
        logic [NS-1:0] cap;
        logic [1:0]    eovf;
        cap  = '0;
        eovf = '0;
        for (int p = 0; p < NP; p++) begin
            int ts;
            bit got;
            ts = p * SL + ((p == 0) ? s0 : s1);
            if (txm[p]) begin
                if (m_v[ts]) eovf[p] = 1'b1;
                else         cap[ts] = 1'b1;
            end
            if (rxm[p]) begin
                got = 1'b0;
                for (int i = 0; i < SL; i++) begin
                    if (!got && !m_v[p*SL+i] && !(txm[p] && (p*SL+i) == ts)) begin
                        cap[p*SL+i] = 1'b1;
                        got = 1'b1;
                    end
                end
                if (!got) eovf[p] = 1'b1;
            end
        end
        rx_cap    = rxm;
        tx_cap    = txm;
        tx_slot   = {2'(s1), 2'(s0)};
        timer     = t;
        reg_wr    = wr;
        reg_addr  = a;
        reg_wdata = wd;
        @(negedge clk);
        rx_cap = '0;
        tx_cap = '0;
        reg_wr = 1'b0;
        if (wr && wd == '0) begin
            if (a[3]) begin m_hi[a[2:0]] = '0; m_v[a[2:0]] = 1'b0; end
            else      m_lo[a[2:0]] = '0;
        end
        for (int s = 0; s < NS; s++) begin
            if (cap[s]) begin
                m_lo[s] = t[55:24];
                m_hi[s] = t[63:56];
                m_v[s]  = 1'b1;
            end
        end
        check({30'b0, ovf}, {30'b0, eovf}, {"R5 ovf after ", tag});
        for (int p = 0; p < NP; p++) begin
            logic pend;
            pend = 1'b0;
            for (int i = 0; i < SL; i++) pend = pend | m_v[p*SL+i];
            check({31'b0, ts_pending[p]}, {31'b0, pend}, {"R10 pending after ", tag});
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin m_lo[s] = '0; m_hi[s] = '0; m_v[s] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(reg_rdata, 32'h0, "R1 rdata after reset");
        check({30'b0, ovf}, 32'h0, "R1 ovf after reset");
        check({30'b0, ts_pending}, 32'h0, "R1 pending after reset");
        for (int s = 0; s < NS; s++) rd(adr(1'b1, s / SL, s % SL), "R1 empty slot");

        // R2 receive captures fill lowest slots
        op(2'b01, 2'b00, 0, 0, 64'h0123_4567_89AB_CDEF, 1'b0, 4'h0, 32'h0, "rx p0 #1");
        rd(adr(1'b0, 0, 0), "R2 low word slot0");
        rd(adr(1'b1, 0, 0), "R2 high word slot0 R6");
        op(2'b01, 2'b00, 0, 0, 64'hFEDC_BA98_7654_3210, 1'b0, 4'h0, 32'h0, "rx p0 #2");
        rd(adr(1'b0, 0, 1), "R2 low word slot1");
        rd(adr(1'b1, 0, 1), "R2 high word slot1");

        // R3 transmit capture into named slot
        op(2'b00, 2'b10, 0, 2, 64'hA5A5_0000_1111_2222, 1'b0, 4'h0, 32'h0, "tx p1 s2");
        rd(adr(1'b0, 1, 2), "R3 low word p1 s2");
        rd(adr(1'b1, 1, 2), "R3 high word p1 s2");
        // R3 no request: timer and slot select change, nothing is stored
        op(2'b00, 2'b00, 3, 3, 64'h7777_8888_9999_AAAA, 1'b0, 4'h0, 32'h0, "no request");
        rd(adr(1'b1, 0, 3), "R3 no capture without request p0");
        rd(adr(1'b1, 1, 3), "R3 no capture without request p1");

        // R4 rx and tx on the same port in one cycle
        op(2'b01, 2'b01, 2, 0, 64'h1357_9BDF_2468_ACE0, 1'b0, 4'h0, 32'h0, "rx+tx p0");
        rd(adr(1'b1, 0, 2), "R4 tx took named slot2");
        rd(adr(1'b0, 0, 3), "R4 rx took slot3");
        rd(adr(1'b1, 0, 3), "R4 rx slot3 valid");

        // R5 overflow cases
        op(2'b01, 2'b00, 0, 0, 64'hDEAD_BEEF_0000_0000, 1'b0, 4'h0, 32'h0, "rx p0 full");
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b0, 4'h0, 32'h0, "idle after ovf");
        op(2'b00, 2'b01, 1, 0, 64'hCAFE_F00D_0000_0000, 1'b0, 4'h0, 32'h0, "tx p0 s1 busy");
        rd(adr(1'b0, 0, 1), "R5 dropped tx leaves slot1");
        rd(adr(1'b1, 0, 1), "R5 dropped tx leaves slot1 high");

        // R8 nonzero writes ignored
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b1, 0, 0), 32'h0000_0001, "nonzero hi wr");
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b0, 0, 0), 32'h8000_0000, "nonzero lo wr");
        rd(adr(1'b1, 0, 0), "R8 high unchanged");
        rd(adr(1'b0, 0, 0), "R8 low unchanged");

        // R7 zero writes clear and release
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b0, 0, 0), 32'h0, "clear lo s0");
        rd(adr(1'b0, 0, 0), "R7 low cleared");
        rd(adr(1'b1, 0, 0), "R7 still valid after low clear");
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b1, 0, 0), 32'h0, "clear hi s0");
        rd(adr(1'b1, 0, 0), "R7 high and valid cleared");
        op(2'b01, 2'b00, 0, 0, 64'h2468_1357_ABCD_EF01, 1'b0, 4'h0, 32'h0, "rx p0 reuse");
        rd(adr(1'b0, 0, 0), "R7 released slot reused");

        // R9 capture wins over clear on the same slot
        op(2'b00, 2'b10, 0, 3, 64'h55AA_33CC_0F0F_F0F0, 1'b1, adr(1'b1, 1, 3), 32'h0, "tx+clear p1 s3");
        rd(adr(1'b1, 1, 3), "R9 capture kept");
        rd(adr(1'b0, 1, 3), "R9 capture low");

        // R10 pending drops when port empties
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b1, 1, 2), 32'h0, "clear p1 s2");
        op(2'b00, 2'b00, 0, 0, 64'h0, 1'b1, adr(1'b1, 1, 3), 32'h0, "clear p1 s3");

        idle(3);
        if (exp_q.size() != 0) check(32'(exp_q.size()), 32'h0, "R6 reads outstanding");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule